// File: doc/BRIEF.md
# Iterative Shift Rotate Unit

This unit shifts or rotates an 8-bit or 16-bit value by a count and moves one bit position per clock. A single-cycle `start` pulse captures the operand, the operand size, the operation code, the count source and the incoming carry, parity, sign and zero flags. Each following clock applies one single-bit step in which the carry takes part. After the last step the unit presents the result and the new flags, and raises `done` for one cycle.

The count is either a fixed single step or the value of an 8-bit count input. A count of zero finishes at once and leaves the operand and all the flags as they were. Shifts take parity, sign and zero from the result. Rotates hand those three flags back exactly as they came in and change only the carry. In byte mode only the low eight bits move, and the high byte of the operand is returned as it was.

Top module: `shrot_engine`

## Requirements
- R1: Operation code 0 (and code 7, which acts the same) is a left shift: at each step the top active bit goes to the carry and bit 0 is filled with 0.
- R2: Operation code 1 is a logical right shift: at each step bit 0 goes to the carry and the top active bit is filled with 0.
- R3: Operation code 2 is an arithmetic right shift: at each step bit 0 goes to the carry and the top active bit keeps its value.
- R4: Code 3 rotates left, copying the top active bit into both the carry and bit 0. Code 4 rotates right, copying bit 0 into both the carry and the top active bit.
- R5: Code 5 rotates left through the carry, so the top active bit goes to the carry and the old carry goes to bit 0. Code 6 rotates right through the carry, so bit 0 goes to the carry and the old carry goes to the top active bit.
- R6: With `cnt_sel`=0 exactly one step is done and `cnt_in` is ignored. With `cnt_sel`=1, `cnt_in` steps are done. `done` rises N+1 clock edges after the edge that samples `start`, where N is the step count.
- R7: A step count of zero returns the operand unchanged, with `cf_out`, `pf_out`, `sf_out` and `zf_out` equal to the incoming flags.
- R8: After a shift with a nonzero count, `pf_out` is 1 when the low 8 bits of the result hold an even number of ones. `sf_out` is the top active bit of the result. `zf_out` is 1 when all active bits of the result are zero.
- R9: After a rotate, `pf_out`, `sf_out` and `zf_out` equal the incoming `pf_in`, `sf_in` and `zf_in`, even when the rotated value is zero.
- R10: With `wide`=0 the active width is 8 bits (top active bit 7), and `result[15:8]` equals `operand[15:8]`. With `wide`=1 the active width is 16 bits (top active bit 15).
- R11: `busy` is high from the edge after `start` until the edge that raises `done`. `done` is a one-cycle pulse. A `start` while `busy` is high is ignored, and the result and flags are held until the next completion.
- R12: While reset is low, `busy`, `done`, `result` and all the output flags are cleared at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (used only when idle) |
| operand | input | 16 | Value to shift or rotate |
| wide | input | 1 | 1: 16-bit operand, 0: 8-bit operand |
| op | input | 3 | Operation code (see R1 to R5) |
| cnt_sel | input | 1 | 0: one step, 1: step count from `cnt_in` |
| cnt_in | input | 8 | Step count when `cnt_sel`=1 |
| cf_in | input | 1 | Incoming carry |
| pf_in | input | 1 | Incoming parity flag |
| sf_in | input | 1 | Incoming sign flag |
| zf_in | input | 1 | Incoming zero flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 16 | Shifted or rotated value |
| cf_out | output | 1 | Carry after the operation |
| pf_out | output | 1 | Parity flag after the operation |
| sf_out | output | 1 | Sign flag after the operation |
| zf_out | output | 1 | Zero flag after the operation |

## Verification
The assertions check on every cycle the things that hold in every state: the step counter falls by one per clock, the operation registers stay frozen while an operation runs, the high byte stays put during byte operations, `done` lasts one cycle, rotates return the incoming flags, and reset clears the outputs. Only the bench scenarios can show that each operation code moves the right bits into the right places over many steps, with counts such as 8, 9 and 17 that wrap right round. The same goes for the parity, sign and zero values after shifts, the exact completion latency, and the fact that a second `start` during a run has no effect.

// File: rtl/shrot_pkg.sv
// Package: shared operation codes and helpers for the shift/rotate unit.
// Assumes a 3-bit operation code; code 7 is an alias of the left shift.
package shrot_pkg;

    typedef enum logic [2:0] {
        OP_SHL   = 3'd0,
        OP_SHR   = 3'd1,
        OP_SAR   = 3'd2,
        OP_ROL   = 3'd3,
        OP_ROR   = 3'd4,
        OP_RCL   = 3'd5,
        OP_RCR   = 3'd6,
        OP_SHL2  = 3'd7
    } shrot_op_e;

    // True for codes whose result drives parity, sign and zero.
    function automatic logic op_is_shift(input logic [2:0] code);
        return (code == OP_SHL) || (code == OP_SHR) ||
               (code == OP_SAR) || (code == OP_SHL2);
    endfunction

endpackage

// File: rtl/shrot_step.sv
// Module: one single-bit shift/rotate step, purely combinational.
// Assumes NARROW_W < DATA_W; in narrow mode the bits above NARROW_W pass through.
module shrot_step
    import shrot_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic [DATA_W-1:0] val,
    input  logic              cin,
    input  logic              wide,
    input  logic [2:0]        op,
    output logic [DATA_W-1:0] nval,
    output logic              cout
);
    localparam int HI_W = DATA_W - NARROW_W;

    logic [DATA_W-1:0] lane;
    logic [DATA_W-1:0] lane_n;
    int unsigned       msb;

    // Select the active lane and the index of its top bit.
    always_comb begin
        msb  = wide ? DATA_W - 1 : NARROW_W - 1;
        lane = wide ? val : {{HI_W{1'b0}}, val[NARROW_W-1:0]};
    end

    // Apply one step of the chosen operation to the active lane.
    always_comb begin
        lane_n = lane;
        cout   = cin;
        case (shrot_op_e'(op))
            OP_SHR: begin
                cout        = lane[0];
                lane_n      = lane >> 1;
                lane_n[msb] = 1'b0;
            end
            OP_SAR: begin
                cout        = lane[0];
                lane_n      = lane >> 1;
                lane_n[msb] = lane[msb];
            end
            OP_ROL: begin
                cout      = lane[msb];
                lane_n    = lane << 1;
                lane_n[0] = lane[msb];
            end
            OP_ROR: begin
                cout        = lane[0];
                lane_n      = lane >> 1;
                lane_n[msb] = lane[0];
            end
            OP_RCL: begin
                cout      = lane[msb];
                lane_n    = lane << 1;
                lane_n[0] = cin;
            end
            OP_RCR: begin
                cout        = lane[0];
                lane_n      = lane >> 1;
                lane_n[msb] = cin;
            end
            default: begin
                cout      = lane[msb];
                lane_n    = lane << 1;
                lane_n[0] = 1'b0;
            end
        endcase
    end

    // Reassemble the full word, keeping the inactive high bits.
    always_comb begin
        nval = wide ? lane_n : {val[DATA_W-1:NARROW_W], lane_n[NARROW_W-1:0]};
    end

endmodule

// File: rtl/shrot_flags.sv
// Module: parity, sign and zero of a result for the active width.
// Assumes parity is always taken over the low NARROW_W bits.
module shrot_flags #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic [DATA_W-1:0] res,
    input  logic              wide,
    output logic              pf,
    output logic              sf,
    output logic              zf
);
    // Derive the three result flags.
    always_comb begin
        pf = ~^res[NARROW_W-1:0];
        sf = wide ? res[DATA_W-1] : res[NARROW_W-1];
        zf = wide ? (res == '0) : (res[NARROW_W-1:0] == '0);
    end

endmodule

// File: rtl/shrot_ctrl.sv
// Module: step counter and busy control for the iterative unit.
// Assumes start is honoured only while idle; one step per clock while busy.
module shrot_ctrl #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cnt_sel,
    input  logic [CNT_W-1:0] cnt_in,
    output logic             busy,
    output logic             load,
    output logic             step_en,
    output logic             finish,
    output logic             cnt_zero
);
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] cnt_pick;

    // Choose the step count and decode the control strobes.
    always_comb begin
        cnt_pick = cnt_sel ? cnt_in : CNT_W'(1);
        load     = start & ~busy;
        step_en  = busy & (remain != '0);
        finish   = busy & (remain == '0);
    end

    // Load, count down and retire the step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            remain   <= '0;
            cnt_zero <= 1'b0;
        end else if (load) begin
            busy     <= 1'b1;
            remain   <= cnt_pick;
            cnt_zero <= (cnt_pick == '0);
        end else if (finish) begin
            busy <= 1'b0;
        end else if (step_en) begin
            remain <= remain - 1'b1;
        end
    end

    assert_count_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (remain == $past(remain) - 1'b1));

    assert_finish_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !busy);

endmodule

// File: rtl/shrot_engine.sv
// Module: top of the iterative shift/rotate unit.
// Assumes DATA_W-bit wide mode and NARROW_W-bit narrow mode; outputs
// are registered and held between completions.
module shrot_engine
    import shrot_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int CNT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] operand,
    input  logic              wide,
    input  logic [2:0]        op,
    input  logic              cnt_sel,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              cf_in,
    input  logic              pf_in,
    input  logic              sf_in,
    input  logic              zf_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              cf_out,
    output logic              pf_out,
    output logic              sf_out,
    output logic              zf_out
);
    logic              load, step_en, finish, cnt_zero;
    logic [DATA_W-1:0] work, work_n;
    logic              carry, carry_n;
    logic [2:0]        op_q;
    logic              wide_q;
    logic              pfi_q, sfi_q, zfi_q;
    logic              rpf, rsf, rzf;
    logic              use_res_flags;

    shrot_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cnt_sel(cnt_sel),
        .cnt_in(cnt_in), .busy(busy), .load(load), .step_en(step_en),
        .finish(finish), .cnt_zero(cnt_zero)
    );

    shrot_step #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_step (
        .val(work), .cin(carry), .wide(wide_q), .op(op_q),
        .nval(work_n), .cout(carry_n)
    );

    shrot_flags #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_flags (
        .res(work), .wide(wide_q), .pf(rpf), .sf(rsf), .zf(rzf)
    );

    // Shifts with a nonzero count take their flags from the result.
    always_comb begin
        use_res_flags = op_is_shift(op_q) & ~cnt_zero;
    end

    // Capture the request, then advance the working value one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work   <= '0;
            carry  <= 1'b0;
            op_q   <= 3'd0;
            wide_q <= 1'b0;
            pfi_q  <= 1'b0;
            sfi_q  <= 1'b0;
            zfi_q  <= 1'b0;
        end else if (load) begin
            work   <= operand;
            carry  <= cf_in;
            op_q   <= op;
            wide_q <= wide;
            pfi_q  <= pf_in;
            sfi_q  <= sf_in;
            zfi_q  <= zf_in;
        end else if (step_en) begin
            work  <= work_n;
            carry <= carry_n;
        end
    end

    // Publish result and flags at completion and pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
            cf_out <= 1'b0;
            pf_out <= 1'b0;
            sf_out <= 1'b0;
            zf_out <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                result <= work;
                cf_out <= carry;
                pf_out <= use_res_flags ? rpf : pfi_q;
                sf_out <= use_res_flags ? rsf : sfi_q;
                zf_out <= use_res_flags ? rzf : zfi_q;
            end
        end
    end

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_req_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> ($stable(op_q) && $stable(wide_q)));

    assert_hi_byte_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wide_q) |=> $stable(work[DATA_W-1:NARROW_W]));

    assert_rot_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !op_is_shift(op_q)) |-> (pf_out == pfi_q && sf_out == sfi_q && zf_out == zfi_q));

    assert_reset_clear_R12: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && result == '0));

endmodule

// File: tb/sim_shrot_engine.sv
// Bench: table of vectors walked by one loop, then directed tests.
module sim_shrot_engine;

    typedef struct packed {
        logic [2:0]  op;
        logic        wide;
        logic        csel;
        logic [7:0]  cnt;
        logic [15:0] opnd;
        logic        cfi, pfi, sfi, zfi;
        logic [15:0] res;
        logic        cf, pf, sf, zf;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{3'd0, 1'b1, 1'b0, 8'd0,  16'h8001, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0002, 1'b1, 1'b0, 1'b0, 1'b0},
        '{3'd1, 1'b0, 1'b1, 8'd3,  16'h12F5, 1'b0, 1'b0, 1'b0, 1'b0, 16'h121E, 1'b1, 1'b1, 1'b0, 1'b0},
        '{3'd2, 1'b0, 1'b1, 8'd2,  16'h0084, 1'b0, 1'b0, 1'b0, 1'b0, 16'h00E1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{3'd3, 1'b1, 1'b1, 8'd4,  16'h1234, 1'b0, 1'b1, 1'b1, 1'b0, 16'h2341, 1'b1, 1'b1, 1'b1, 1'b0},
        '{3'd4, 1'b0, 1'b0, 8'd0,  16'hAB01, 1'b0, 1'b0, 1'b1, 1'b1, 16'hAB80, 1'b1, 1'b0, 1'b1, 1'b1},
        '{3'd5, 1'b0, 1'b0, 8'd0,  16'h0080, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0},
        '{3'd6, 1'b1, 1'b0, 8'd0,  16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 16'h8000, 1'b1, 1'b0, 1'b0, 1'b0},
        '{3'd0, 1'b0, 1'b1, 8'd8,  16'h00FF, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1},
        '{3'd5, 1'b1, 1'b1, 8'd17, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b1, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b1},
        '{3'd6, 1'b0, 1'b1, 8'd9,  16'h005A, 1'b1, 1'b1, 1'b1, 1'b1, 16'h005A, 1'b1, 1'b1, 1'b1, 1'b1},
        '{3'd1, 1'b1, 1'b1, 8'd0,  16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b1, 16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b1},
        '{3'd1, 1'b1, 1'b0, 8'd5,  16'h0004, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0002, 1'b0, 1'b0, 1'b0, 1'b0},
        '{3'd7, 1'b0, 1'b0, 8'd0,  16'h3340, 1'b0, 1'b0, 1'b0, 1'b1, 16'h3380, 1'b0, 1'b0, 1'b1, 1'b0},
        '{3'd0, 1'b1, 1'b1, 8'd3,  16'hE000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1},
        '{3'd2, 1'b1, 1'b1, 8'd4,  16'h8010, 1'b0, 1'b0, 1'b0, 1'b0, 16'hF801, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] operand = '0;
    logic        wide = 1'b0;
    logic [2:0]  op = '0;
    logic        cnt_sel = 1'b0;
    logic [7:0]  cnt_in = '0;
    logic        cf_in = 1'b0, pf_in = 1'b0, sf_in = 1'b0, zf_in = 1'b0;
    logic        busy, done, cf_out, pf_out, sf_out, zf_out;
    logic [15:0] result;

    int total = 0;
    int failed = 0;

    always #5 clk = ~clk;

    shrot_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand), .wide(wide),
        .op(op), .cnt_sel(cnt_sel), .cnt_in(cnt_in), .cf_in(cf_in), .pf_in(pf_in),
        .sf_in(sf_in), .zf_in(zf_in), .busy(busy), .done(done), .result(result),
        .cf_out(cf_out), .pf_out(pf_out), .sf_out(sf_out), .zf_out(zf_out)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string op_req(input logic [2:0] code);
        case (code)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3, 3'd4: return "R4";
            3'd5, 3'd6: return "R5";
            default: return "R1";
        endcase
    endfunction

    // Drive one vector, wait for done, return the number of edges taken.
    task automatic run_vec(input vec_t v, output int lat);
        operand = v.opnd; wide = v.wide; op = v.op; cnt_sel = v.csel; cnt_in = v.cnt;
        cf_in = v.cfi; pf_in = v.pfi; sf_in = v.sfi; zf_in = v.zfi;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #2000000;
        total++;
        failed++;
        $display("FAIL R11 watchdog: actual 0 expected 1");
        $display("  %0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        int lat;
        int steps;
        // Reset state (R12)
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R12", "busy after reset", {31'd0, busy}, 32'd0);
        check("R12", "done after reset", {31'd0, done}, 32'd0);
        check("R12", "result/flags after reset", {12'd0, result, cf_out, pf_out, sf_out, zf_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_vec(TBL[i], lat);
            steps = TBL[i].csel ? int'(TBL[i].cnt) : 1;
            check(op_req(TBL[i].op), $sformatf("vec %0d result", i), {16'd0, result}, {16'd0, TBL[i].res});
            check(op_req(TBL[i].op), $sformatf("vec %0d carry", i), {31'd0, cf_out}, {31'd0, TBL[i].cf});
            check((TBL[i].op inside {3'd3, 3'd4, 3'd5, 3'd6}) ? "R9" :
                  (steps == 0 ? "R7" : "R8"),
                  $sformatf("vec %0d pf/sf/zf", i),
                  {29'd0, pf_out, sf_out, zf_out}, {29'd0, TBL[i].pf, TBL[i].sf, TBL[i].zf});
            check("R6", $sformatf("vec %0d latency", i), lat, steps + 1);
            if (!TBL[i].wide)
                check("R10", $sformatf("vec %0d high byte", i), {24'd0, result[15:8]}, {24'd0, TBL[i].opnd[15:8]});
            @(negedge clk);
            check("R11", $sformatf("vec %0d done one cycle", i), {30'd0, done, busy}, 32'd0);
        end

        // Start while busy is ignored (R11)
        operand = 16'h00F0; wide = 1'b1; op = 3'd3; cnt_sel = 1'b1; cnt_in = 8'd4;
        cf_in = 1'b0; pf_in = 1'b0; sf_in = 1'b0; zf_in = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R11", "busy during run", {31'd0, busy}, 32'd1);
        @(negedge clk);
        operand = 16'hFFFF; op = 3'd1; cnt_in = 8'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 2;
        while (!done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        check("R11", "busy-start ignored result", {16'd0, result}, 32'h00000F00);
        check("R11", "busy-start latency unchanged", lat, 5);
        @(negedge clk);
        @(negedge clk);
        check("R11", "no second completion", {31'd0, done}, 32'd0);
        check("R11", "held result", {16'd0, result}, 32'h00000F00);

        // Reset in the middle of a run (R12)
        operand = 16'h1111; op = 3'd0; cnt_sel = 1'b1; cnt_in = 8'd20; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12", "busy cleared mid-run", {31'd0, busy}, 32'd0);
        check("R12", "result cleared mid-run", {16'd0, result}, 32'd0);
        rst_n = 1'b1;

        $display("  %0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule